// File: doc/BRIEF.md
# Debug Breakpoint Match Unit

This unit keeps four debug address slots, a control word and a status word, and watches a processor's instruction fetch stream and data access stream for breakpoint and watchpoint hits. Each slot is given a kind by the control word: execute, data write, I/O, or data read/write. An execute slot fires when the fetched instruction address equals the slot address. A data slot fires when the bytes touched by an access overlap the naturally aligned window that the slot address and its length code select.

In any cycle with a fetch, an access or a forced update, the unit works out a four-bit hit vector. Every slot that matches sets its bit, whether it is enabled or not. That vector replaces the low four status bits only when an enabled slot matched or the force input is high. An enabled hit also raises a one-cycle debug exception request. The upper status bits belong to software and are never changed by a hit. Both streams are accepted on every cycle that their valid input is high. The unit has no ready output and never applies back-pressure, so a beat is taken in the cycle it is presented.

Top module: `dbgm_unit`

## Requirements
- R1: After reset, all four slot addresses, the control word, the status word and the exception request are zero.
- R2: A write with `cfg_wr_en` high stores `cfg_wr_data` at the next clock edge. Selector 0..3 picks a slot address, 4 picks the control word, and 5 picks the status word. The control word appears on `ctrl_o` and the status word appears on `status_o`.
- R3: Control bits [16+4i+1:16+4i] give the kind of slot i: 00 execute, 01 data write, 10 I/O, 11 data read/write. An execute slot matches only in a cycle with `fetch_valid` high and `fetch_pc` equal to its address.
- R4: A data-write slot matches only accesses with `acc_write` high whose byte range overlaps its window.
- R5: A data read/write slot matches both reads and writes whose byte range overlaps its window.
- R6: An I/O slot never matches.
- R7: Control bits [16+4i+3:16+4i+2] give the window length of slot i: 00=1, 01=2, 11=4, 10=8 bytes. The window starts at the slot address with its low bits cleared to that length. An access covers 2^`acc_size` bytes starting at `acc_addr`.
- R8: When an enabled slot matches, or `force_update` is high, the low four status bits become the hit vector (bit i for slot i) at the next edge. This includes the bits of disabled slots and clears the bits of slots that did not match.
- R9: Slot i is enabled when control bit 2i or bit 2i+1 is set. `dbg_exc_o` is high for exactly the cycle after an evaluation in which an enabled slot matched. A forced update alone never raises it.
- R10: A hit never changes status bits [31:4]. If a status write and a commit fall on the same edge, the upper bits come from the write and the low four bits come from the hit vector.
- R11: In a cycle with no enabled match, no force and no status write, the status word keeps its value, even when a disabled slot matched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 3 | Register selector: 0..3 slot address, 4 control, 5 status |
| cfg_wr_data | input | AW | Register write data |
| fetch_valid | input | 1 | Instruction address valid |
| fetch_pc | input | AW | Current instruction address |
| acc_valid | input | 1 | Data access valid |
| acc_addr | input | AW | Data access start address |
| acc_size | input | 2 | log2 of the access size in bytes |
| acc_write | input | 1 | Access is a write |
| force_update | input | 1 | Commit the hit vector to status without an enabled hit |
| ctrl_o | output | 32 | Control word |
| status_o | output | 32 | Status word |
| dbg_exc_o | output | 1 | Debug exception request pulse |

## Verification
Every result of this unit is due one clock edge after its cause. A register write shows on `ctrl_o` or `status_o` after the edge that takes it. The hit bits and the exception pulse for a fetch or access show after the edge that closes the cycle in which that fetch or access was presented. The bench drives each stimulus on the falling edge and holds it across exactly one rising edge. It samples 1 ns after that rising edge, so each check sees the first cycle of the result, and the cycle after it for the pulse check. The expected status word is kept in the bench as a running model. That model is updated only on commits, which is how it tells a disabled-only hit (no change) from a forced commit.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;
  localparam int NSLOT = 4;
  localparam int CW    = 32;
  localparam int LOWB  = 4;

  typedef enum logic [1:0] {
    BK_EXEC  = 2'b00,
    BK_WRITE = 2'b01,
    BK_IO    = 2'b10,
    BK_RDWR  = 2'b11
  } bk_kind_e;

  typedef enum logic [2:0] {
    SEL_A0   = 3'd0,
    SEL_A1   = 3'd1,
    SEL_A2   = 3'd2,
    SEL_A3   = 3'd3,
    SEL_CTRL = 3'd4,
    SEL_STAT = 3'd5
  } reg_sel_e;

  typedef struct packed {
    logic     en;
    bk_kind_e kind;
    logic [1:0] len;
  } slot_cfg_t;

  function automatic logic [3:0] len_bytes(input logic [1:0] code);
    case (code)
      2'b00:   len_bytes = 4'd1;
      2'b01:   len_bytes = 4'd2;
      2'b11:   len_bytes = 4'd4;
      default: len_bytes = 4'd8;
    endcase
  endfunction

  function automatic slot_cfg_t slot_cfg(input logic [CW-1:0] ctrl, input int idx);
    slot_cfg_t c;
    c.en   = ctrl[2*idx] | ctrl[2*idx+1];
    c.kind = bk_kind_e'(ctrl[16+4*idx +: 2]);
    c.len  = ctrl[18+4*idx +: 2];
    return c;
  endfunction
endpackage

// File: rtl/dbgm_regs.sv
module dbgm_regs
  import dbgm_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [2:0]               wr_sel,
  input  logic [AW-1:0]            wr_data,
  output logic [NSLOT-1:0][AW-1:0] slot_addr,
  output logic [CW-1:0]            ctrl
);
  for (genvar g = 0; g < NSLOT; g++) begin : g_addr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_addr[g] <= '0;
      else if (wr_en && wr_sel == 3'(g))
        slot_addr[g] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctrl <= '0;
    else if (wr_en && wr_sel == SEL_CTRL)
      ctrl <= wr_data[CW-1:0];
  end

  // R2
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_CTRL) |=> (ctrl == $past(wr_data[CW-1:0])));
endmodule

// File: rtl/dbgm_slot.sv
module dbgm_slot
  import dbgm_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  slot_cfg_t      cfg,
  input  logic [AW-1:0]  slot_addr,
  input  logic           fetch_valid,
  input  logic [AW-1:0]  fetch_pc,
  input  logic           acc_valid,
  input  logic [AW-1:0]  acc_addr,
  input  logic [1:0]     acc_size,
  input  logic           acc_write,
  output logic           hit
);
  localparam int XW = AW + 1;

  logic [AW-1:0] win_mask;
  logic [AW-1:0] win_base;
  logic [XW-1:0] win_last;
  logic [XW-1:0] acc_first;
  logic [XW-1:0] acc_last;
  logic          overlap;

  always_comb begin
    win_mask  = AW'(len_bytes(cfg.len)) - AW'(1);
    win_base  = slot_addr & ~win_mask;
    win_last  = {1'b0, win_base} + {1'b0, win_mask};
    acc_first = {1'b0, acc_addr};
    acc_last  = acc_first + ((XW'(1) << acc_size) - XW'(1));
    overlap   = (acc_first <= win_last) && ({1'b0, win_base} <= acc_last);
  end

  always_comb begin
    case (cfg.kind)
      BK_EXEC:  hit = fetch_valid && (fetch_pc == slot_addr);
      BK_WRITE: hit = acc_valid && acc_write && overlap;
      BK_RDWR:  hit = acc_valid && overlap;
      default:  hit = 1'b0;
    endcase
  end

  // R6
  io_never_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.kind == BK_IO) |-> !hit);
  // R4
  write_slot_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.kind == BK_WRITE && !acc_write) |-> !hit);
endmodule

// File: rtl/dbgm_status.sv
module dbgm_status
  import dbgm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] hits,
  input  logic [NSLOT-1:0] enables,
  input  logic             force_update,
  input  logic             wr_stat,
  input  logic [CW-1:0]    wr_data,
  output logic [CW-1:0]    status,
  output logic             exc_req
);
  logic en_hit;
  logic commit;

  always_comb begin
    en_hit = |(hits & enables);
    commit = en_hit | force_update;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status  <= '0;
      exc_req <= 1'b0;
    end else begin
      exc_req <= en_hit;
      if (wr_stat)
        status[CW-1:LOWB] <= wr_data[CW-1:LOWB];
      if (commit)
        status[LOWB-1:0] <= hits;
      else if (wr_stat)
        status[LOWB-1:0] <= wr_data[LOWB-1:0];
    end
  end

  // R9
  exc_has_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (status[LOWB-1:0] != '0));
  // R10
  upper_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> $stable(status[CW-1:LOWB]));
  // R11
  no_commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_hit && !force_update && !wr_stat) |=> $stable(status));
  // R8
  commit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (status[LOWB-1:0] == $past(hits)));
endmodule

// File: rtl/dbgm_unit.sv
module dbgm_unit
  import dbgm_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr_en,
  input  logic [2:0]    cfg_wr_sel,
  input  logic [AW-1:0] cfg_wr_data,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_pc,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic [1:0]    acc_size,
  input  logic          acc_write,
  input  logic          force_update,
  output logic [31:0]   ctrl_o,
  output logic [31:0]   status_o,
  output logic          dbg_exc_o
);
  logic [NSLOT-1:0][AW-1:0] slot_addr;
  logic [CW-1:0]            ctrl;
  logic [NSLOT-1:0]         hits;
  logic [NSLOT-1:0]         enables;
  logic [CW-1:0]            status;
  logic                     exc_req;

  dbgm_regs #(.AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr_en),
    .wr_sel    (cfg_wr_sel),
    .wr_data   (cfg_wr_data),
    .slot_addr (slot_addr),
    .ctrl      (ctrl)
  );

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    slot_cfg_t cfg;
    assign cfg        = slot_cfg(ctrl, g);
    assign enables[g] = cfg.en;
    dbgm_slot #(.AW(AW)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg         (cfg),
      .slot_addr   (slot_addr[g]),
      .fetch_valid (fetch_valid),
      .fetch_pc    (fetch_pc),
      .acc_valid   (acc_valid),
      .acc_addr    (acc_addr),
      .acc_size    (acc_size),
      .acc_write   (acc_write),
      .hit         (hits[g])
    );
  end

  dbgm_status u_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .hits         (hits),
    .enables      (enables),
    .force_update (force_update),
    .wr_stat      (cfg_wr_en && cfg_wr_sel == SEL_STAT),
    .wr_data      (cfg_wr_data[CW-1:0]),
    .status       (status),
    .exc_req      (exc_req)
  );

  assign ctrl_o    = ctrl;
  assign status_o  = status;
  assign dbg_exc_o = exc_req;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (status_o == '0 && !dbg_exc_o));
endmodule

// File: tb/test_dbgm_unit.sv
module test_dbgm_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [2:0]  cfg_wr_sel = '0;
  logic [31:0] cfg_wr_data = '0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_size = '0;
  logic        acc_write = 1'b0;
  logic        force_update = 1'b0;
  logic [31:0] ctrl_o;
  logic [31:0] status_o;
  logic        dbg_exc_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] model_stat = '0;

  always #2 clk = ~clk;

  dbgm_unit #(.AW(32)) i_dbgm_unit (.*);

  typedef struct packed {
    logic        fv;
    logic [31:0] pc;
    logic        av;
    logic [31:0] aa;
    logic [1:0]  asz;
    logic        aw;
    logic        frc;
    logic [3:0]  hits;
    logic        exc;
  } vec_t;

  // slot0 exec 0x1000 en; slot1 write len4 0x2004 en; slot2 I/O 0x3000 en; slot3 rdwr len8 0x4000 off
  localparam logic [31:0] CTRL_A = 32'hB2D0_0019;
  localparam vec_t VECS [14] = '{
    '{1'b1, 32'h1000, 1'b0, 32'h0,    2'd0, 1'b0, 1'b0, 4'b0001, 1'b1}, // R3
    '{1'b1, 32'h1004, 1'b0, 32'h0,    2'd0, 1'b0, 1'b0, 4'b0000, 1'b0}, // R3 R11
    '{1'b0, 32'h0,    1'b1, 32'h2006, 2'd0, 1'b1, 1'b0, 4'b0010, 1'b1}, // R4
    '{1'b0, 32'h0,    1'b1, 32'h2004, 2'd2, 1'b0, 1'b0, 4'b0000, 1'b0}, // R4
    '{1'b0, 32'h0,    1'b1, 32'h2002, 2'd2, 1'b1, 1'b0, 4'b0010, 1'b1}, // R7
    '{1'b0, 32'h0,    1'b1, 32'h2000, 2'd2, 1'b1, 1'b0, 4'b0000, 1'b0}, // R7
    '{1'b0, 32'h0,    1'b1, 32'h4006, 2'd1, 1'b0, 1'b0, 4'b1000, 1'b0}, // R11
    '{1'b0, 32'h0,    1'b1, 32'h4006, 2'd1, 1'b0, 1'b1, 4'b1000, 1'b0}, // R8
    '{1'b0, 32'h0,    1'b1, 32'h3000, 2'd0, 1'b1, 1'b1, 4'b0000, 1'b0}, // R6
    '{1'b1, 32'h1000, 1'b1, 32'h4000, 2'd3, 1'b1, 1'b0, 4'b1001, 1'b1}, // R5 R8
    '{1'b0, 32'h0,    1'b1, 32'h2008, 2'd0, 1'b1, 1'b0, 4'b0000, 1'b0}, // R7
    '{1'b0, 32'h0,    1'b1, 32'h3FFC, 2'd3, 1'b0, 1'b0, 4'b1000, 1'b0}, // R7 R11
    '{1'b1, 32'h1000, 1'b1, 32'h2005, 2'd0, 1'b0, 1'b0, 4'b0001, 1'b1}, // R4
    '{1'b0, 32'h0,    1'b0, 32'h0,    2'd0, 1'b0, 1'b1, 4'b0000, 1'b0}  // R8
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = data;
    @(posedge clk); #1;
    cfg_wr_en = 1'b0;
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    fetch_valid = v.fv; fetch_pc = v.pc; acc_valid = v.av; acc_addr = v.aa;
    acc_size = v.asz; acc_write = v.aw; force_update = v.frc;
    @(posedge clk); #1;
    fetch_valid = 1'b0; acc_valid = 1'b0; force_update = 1'b0;
    if (v.exc || v.frc) model_stat[3:0] = v.hits;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #9;
    chk("R1 status", status_o, 32'h0);
    chk("R1 ctrl", ctrl_o, 32'h0);
    chk("R1 exc", {31'b0, dbg_exc_o}, 32'h0);
    rst_n = 1'b1;

    wr_reg(3'd0, 32'h1000);
    wr_reg(3'd1, 32'h2004);
    wr_reg(3'd2, 32'h3000);
    wr_reg(3'd3, 32'h4000);
    wr_reg(3'd4, CTRL_A);
    chk("R2 ctrl", ctrl_o, CTRL_A);

    for (int i = 0; i < 14; i++) begin
      apply(VECS[i]);
      chk($sformatf("R8 status vec%0d", i), status_o, model_stat);
      chk($sformatf("R9 exc vec%0d", i), {31'b0, dbg_exc_o}, {31'b0, VECS[i].exc});
    end

    // R2 status write, then R10 upper kept across a hit
    wr_reg(3'd5, 32'hABCD_0000);
    chk("R2 status", status_o, 32'hABCD_0000);
    apply('{1'b1, 32'h1000, 1'b0, 32'h0, 2'd0, 1'b0, 1'b0, 4'b0001, 1'b1});
    chk("R10 upper kept", status_o, 32'hABCD_0001);
    // R9 pulse lasts one cycle
    @(posedge clk); #1;
    chk("R9 pulse end", {31'b0, dbg_exc_o}, 32'h0);

    // R10 write and commit on the same edge
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = 3'd5; cfg_wr_data = 32'h1234_0006;
    fetch_valid = 1'b1; fetch_pc = 32'h1000;
    @(posedge clk); #1;
    cfg_wr_en = 1'b0; fetch_valid = 1'b0;
    chk("R10 write+commit", status_o, 32'h1234_0001);

    // R3 matching pc without valid does not hit; forced commit clears, no exception
    @(negedge clk);
    fetch_pc = 32'h1000; force_update = 1'b1;
    @(posedge clk); #1;
    force_update = 1'b0;
    chk("R3 no valid", status_o, 32'h1234_0000);
    chk("R9 force no exc", {31'b0, dbg_exc_o}, 32'h0);

    // R9 global enable bit alone enables slot0
    wr_reg(3'd4, CTRL_A ^ 32'h3);
    apply('{1'b1, 32'h1000, 1'b0, 32'h0, 2'd0, 1'b0, 1'b0, 4'b0001, 1'b1});
    chk("R9 global en", {31'b0, dbg_exc_o}, 32'h1);

    // R7 window of slot1 aligns 0x2003 down to 0x2000 with length 4
    wr_reg(3'd1, 32'h2003);
    apply('{1'b0, 32'h0, 1'b1, 32'h2000, 2'd0, 1'b1, 1'b0, 4'b0010, 1'b1});
    chk("R7 align", status_o, 32'h1234_0002);

    // R1 reset clears again
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R1 reset again", status_o, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule